// File: doc/BRIEF.md
# Debug Bus Read Access Engine

This block lets an external debug tool read system memory without involving the processor. The tool loads a start address and then writes a command carrying an access count and an access size. The engine becomes a bus master. It raises a request, waits for a grant and collects read data from the system bus. It leaves the result where the tool can fetch it through a data port. Two status flags report the outcome: one for data ready and one for a bus error.

The count selects one of three behaviours.

- **Single read:** a count of zero or one performs one read.
- **Block read:** a count above one performs a word-by-word block read. The engine stops after every word, and only the tool's read of the data port lets the next access start.
- **Burst read:** a count of four with the 64-bit size performs a four-beat burst under one grant. The burst fills a small buffer, which the tool then drains one double-word per data-port read.

Top module: `dbg_rd_engine`

## Requirements
- R1: A command with count 0 or 1 performs exactly one granted bus access. The fetched data appears on `dat_rdata`, `sts_valid` rises, and the address register keeps its value.
- R2: The size code maps 0/1/2/3 to 8/16/32/64-bit accesses. In the multi-access modes each error-free beat advances the address by 1, 2, 4 or 8 bytes to match.
- R3: A command with count above 1 that does not select burst mode runs as a block read, which includes count 4 with sizes 0 to 2. Each error-free word decrements the count by one and puts the word on `dat_rdata`. The engine then issues no further bus request until the tool pulses `dat_re`.
- R4: During a block read `sts_valid` stays low until the count reaches zero, and it rises together with that last word.
- R5: Count 4 with size 3 is a burst. Exactly one grant is requested, with `bus_burst` high, and four beats follow back to back. At the end the address has advanced by 32, the count is 0, and `sts_valid` rises only after the fourth error-free beat.
- R6: After a burst, `dat_rdata` shows the buffered double-words in address order. Each `dat_re` pulse moves to the next one, and the fourth one stays on the port after further pulses.
- R7: A beat that returns `bus_err` has the following effects:
  - `sts_err` is set and `sts_valid` stays low.
  - No further bus request is made.
  - Count and address keep the values reached before the failing beat.
- R8: While an access is in progress, including the wait for the tool in block mode, writes to the command and to the address are ignored.
- R9: The following hold for reset and for an accepted command:
  - Reset leaves both flags and `bus_req` low.
  - An accepted command clears both flags on the next cycle.
  - An accepted command raises `bus_req` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Write strobe for a new command |
| ctl_cnt | input | CNT_W | Access count of the command |
| ctl_size | input | 2 | Access size code (0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = 64-bit) |
| adr_we | input | 1 | Write strobe for the address register |
| adr_wdata | input | AW | Start address |
| dat_re | input | 1 | Tool read of the data port (advances block reads or the burst buffer) |
| dat_rdata | output | 64 | Read data presented to the tool |
| sts_valid | output | 1 | Data-valid flag |
| sts_err | output | 1 | Bus error flag |
| sts_cnt | output | CNT_W | Remaining count |
| sts_addr | output | AW | Current address register |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| bus_addr | output | AW | Address of the current beat |
| bus_size | output | 2 | Size code of the access |
| bus_burst | output | 1 | Marks a four-beat burst access |
| bus_rvalid | input | 1 | A read beat is returned |
| bus_err | input | 1 | The returned beat carries an error |
| bus_rdata | input | 64 | Read data of the beat |

## Verification
The bench sweeps every size code against counts 0 and 1 for single reads, and against counts 2 to 5 for block reads. It uses a memory model whose data is a function of the address, so a wrong increment or a wrong beat order shows up as a data mismatch.

Count 4 appears both with 32-bit and with 64-bit size, which tells block mode apart from burst mode. Block mode requires a `dat_re` pulse per word, while burst mode needs a single grant.

Errors are injected at the first beat of a single read and at the third beat of a burst, which separates "stop and keep progress" from "roll back". Command and address writes are also placed inside a block read's wait, to show they leave the count and address untouched.

// File: rtl/dbg_rd_pkg.sv
package dbg_rd_pkg;

  localparam int BURST_BEATS = 4;
  localparam int BEAT_W      = $clog2(BURST_BEATS);

  typedef enum logic [1:0] {
    MD_SINGLE = 2'd0,
    MD_BLOCK  = 2'd1,
    MD_BURST  = 2'd2
  } acc_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_XFER = 2'd2,
    ST_HOLD = 2'd3
  } eng_state_e;

  // bytes moved by one access of the given size code
  function automatic logic [3:0] size_bytes(input logic [1:0] sz);
    return 4'd1 << sz;
  endfunction

  // how a command with this count and size is carried out
  function automatic acc_mode_e pick_mode(input int unsigned cnt, input logic [1:0] sz);
    if (cnt <= 1) return MD_SINGLE;
    if (cnt == BURST_BEATS && sz == 2'd3) return MD_BURST;
    return MD_BLOCK;
  endfunction

endpackage

// File: rtl/dbg_rd_ctrl.sv
module dbg_rd_ctrl
  import dbg_rd_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int AW    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic [CNT_W-1:0]  ctl_cnt,
  input  logic [1:0]        ctl_size,
  input  logic              adr_we,
  input  logic [AW-1:0]     adr_wdata,
  input  logic              dat_re,
  input  logic              bus_gnt,
  input  logic              bus_rvalid,
  input  logic              bus_err,
  output logic              bus_req,
  output logic [AW-1:0]     bus_addr,
  output logic [1:0]        bus_size,
  output logic              bus_burst,
  output logic              sts_valid,
  output logic              sts_err,
  output logic [CNT_W-1:0]  sts_cnt,
  output logic [AW-1:0]     sts_addr,
  output logic              cmd_accept,
  output logic              wr_en,
  output logic [BEAT_W-1:0] wr_idx,
  output logic              pop_en
);

  eng_state_e        state_q, state_nx;
  acc_mode_e         mode_q;
  logic [1:0]        size_q;
  logic [CNT_W-1:0]  cnt_q, cnt_next;
  logic [AW-1:0]     addr_q, addr_next;
  logic [BEAT_W-1:0] beat_q;
  logic              valid_q, err_q;

  // named internal events
  logic busy, adr_accept, beat_evt, beat_ok, beat_bad, done_evt;

  assign busy       = (state_q != ST_IDLE);
  assign cmd_accept = ctl_we && !busy;
  assign adr_accept = adr_we && !busy;
  assign beat_evt   = (state_q == ST_XFER) && bus_rvalid;
  assign beat_ok    = beat_evt && !bus_err;
  assign beat_bad   = beat_evt && bus_err;

  always_comb begin
    case (mode_q)
      MD_SINGLE: done_evt = beat_ok;
      MD_BLOCK:  done_evt = beat_ok && (cnt_q == CNT_W'(1));
      MD_BURST:  done_evt = beat_ok && (beat_q == BEAT_W'(BURST_BEATS - 1));
      default:   done_evt = 1'b0;
    endcase
  end

  always_comb begin
    if (mode_q == MD_SINGLE) begin
      cnt_next  = '0;
      addr_next = addr_q;
    end else begin
      cnt_next  = cnt_q - CNT_W'(1);
      addr_next = addr_q + AW'(size_bytes(size_q));
    end
  end

  always_comb begin
    state_nx = state_q;
    case (state_q)
      ST_IDLE: if (cmd_accept) state_nx = ST_REQ;
      ST_REQ:  if (bus_gnt) state_nx = ST_XFER;
      ST_XFER: begin
        if (beat_bad) state_nx = ST_IDLE;
        else if (beat_ok) begin
          if (done_evt) state_nx = ST_IDLE;
          else if (mode_q == MD_BLOCK) state_nx = ST_HOLD;
          else state_nx = ST_XFER;
        end
      end
      ST_HOLD: if (dat_re) state_nx = ST_REQ;
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mode_q  <= MD_SINGLE;
      size_q  <= '0;
      cnt_q   <= '0;
      addr_q  <= '0;
      beat_q  <= '0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_nx;
      if (adr_accept) addr_q <= adr_wdata;
      if (cmd_accept) begin
        cnt_q   <= ctl_cnt;
        size_q  <= ctl_size;
        mode_q  <= pick_mode(32'(ctl_cnt), ctl_size);
        beat_q  <= '0;
        valid_q <= 1'b0;
        err_q   <= 1'b0;
      end
      if (beat_ok) begin
        cnt_q  <= cnt_next;
        addr_q <= addr_next;
        beat_q <= beat_q + BEAT_W'(1);
      end
      if (done_evt) valid_q <= 1'b1;
      if (beat_bad) err_q <= 1'b1;
    end
  end

  assign bus_req   = (state_q == ST_REQ);
  assign bus_addr  = addr_q;
  assign bus_size  = size_q;
  assign bus_burst = (mode_q == MD_BURST);
  assign sts_valid = valid_q;
  assign sts_err   = err_q;
  assign sts_cnt   = cnt_q;
  assign sts_addr  = addr_q;
  assign wr_en     = beat_ok;
  assign wr_idx    = (mode_q == MD_BURST) ? beat_q : '0;
  assign pop_en    = valid_q && (mode_q == MD_BURST);

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(sts_valid && sts_err)); // R7
  AST_VALID_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_valid) |-> sts_cnt == '0); // R4
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    beat_ok && mode_q != MD_SINGLE |=> sts_cnt == $past(sts_cnt) - CNT_W'(1)); // R3
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    beat_ok && mode_q != MD_SINGLE |=> sts_addr == $past(sts_addr) + AW'(size_bytes($past(bus_size)))); // R2
  AST_BUSY_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    busy && (ctl_we || adr_we) && !beat_evt |=> $stable(sts_cnt) && $stable(sts_addr) && $stable(bus_size)); // R8
  AST_CMD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_accept |=> !sts_valid && !sts_err && bus_req); // R9
  AST_ERR_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    beat_bad |=> !bus_req && $stable(sts_cnt) && $stable(sts_addr)); // R7

endmodule

// File: rtl/dbg_rd_buf.sv
module dbg_rd_buf
  import dbg_rd_pkg::*;
#(
  parameter int DW    = 64,
  parameter int DEPTH = BURST_BEATS
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     fill_start,
  input  logic                     wr_en,
  input  logic [$clog2(DEPTH)-1:0] wr_idx,
  input  logic [DW-1:0]            wr_data,
  input  logic                     pop_en,
  input  logic                     dat_re,
  output logic [DW-1:0]            rd_data
);

  localparam int IW = $clog2(DEPTH);
  localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);

  logic [DW-1:0] ent_q [DEPTH];
  logic [IW-1:0] ptr_q;
  logic          pop_evt;

  assign pop_evt = dat_re && pop_en && (ptr_q != LAST);

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ent_q[g] <= '0;
      else if (wr_en && wr_idx == IW'(g)) ent_q[g] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else if (fill_start) ptr_q <= '0;
    else if (pop_evt) ptr_q <= ptr_q + IW'(1);
  end

  assign rd_data = ent_q[ptr_q];

  AST_PTR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !pop_en && !fill_start |=> $stable(ptr_q)); // R6
  AST_PTR_AT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q == LAST && !fill_start |=> ptr_q == LAST); // R6

endmodule

// File: rtl/dbg_rd_engine.sv
module dbg_rd_engine
  import dbg_rd_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int AW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [CNT_W-1:0] ctl_cnt,
  input  logic [1:0]       ctl_size,
  input  logic             adr_we,
  input  logic [AW-1:0]    adr_wdata,
  input  logic             dat_re,
  output logic [63:0]      dat_rdata,
  output logic             sts_valid,
  output logic             sts_err,
  output logic [CNT_W-1:0] sts_cnt,
  output logic [AW-1:0]    sts_addr,
  output logic             bus_req,
  input  logic             bus_gnt,
  output logic [AW-1:0]    bus_addr,
  output logic [1:0]       bus_size,
  output logic             bus_burst,
  input  logic             bus_rvalid,
  input  logic             bus_err,
  input  logic [63:0]      bus_rdata
);

  logic              cmd_accept, wr_en, pop_en;
  logic [BEAT_W-1:0] wr_idx;

  dbg_rd_ctrl #(.CNT_W(CNT_W), .AW(AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .ctl_we(ctl_we), .ctl_cnt(ctl_cnt), .ctl_size(ctl_size),
    .adr_we(adr_we), .adr_wdata(adr_wdata), .dat_re(dat_re),
    .bus_gnt(bus_gnt), .bus_rvalid(bus_rvalid), .bus_err(bus_err),
    .bus_req(bus_req), .bus_addr(bus_addr), .bus_size(bus_size), .bus_burst(bus_burst),
    .sts_valid(sts_valid), .sts_err(sts_err), .sts_cnt(sts_cnt), .sts_addr(sts_addr),
    .cmd_accept(cmd_accept), .wr_en(wr_en), .wr_idx(wr_idx), .pop_en(pop_en)
  );

  dbg_rd_buf #(.DW(64), .DEPTH(BURST_BEATS)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .fill_start(cmd_accept), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(bus_rdata),
    .pop_en(pop_en), .dat_re(dat_re), .rd_data(dat_rdata)
  );

endmodule

// File: tb/tb_dbg_rd_engine.sv
`timescale 1ns/1ps
module tb_dbg_rd_engine;
  localparam int CNT_W = 8;
  localparam int AW    = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_we = 1'b0;
  logic [CNT_W-1:0] ctl_cnt = '0;
  logic [1:0] ctl_size = '0;
  logic adr_we = 1'b0;
  logic [AW-1:0] adr_wdata = '0;
  logic dat_re = 1'b0;
  logic [63:0] dat_rdata;
  logic sts_valid, sts_err, bus_req, bus_burst;
  logic [CNT_W-1:0] sts_cnt;
  logic [AW-1:0] sts_addr, bus_addr;
  logic [1:0] bus_size;
  logic bus_gnt = 1'b0, bus_rvalid = 1'b0, bus_err = 1'b0;
  logic [63:0] bus_rdata = '0;

  int checks = 0, fails = 0, grants = 0, burst_grants = 0;
  int beats_left = 0, beat_no = 0, err_beat = -1, cycles = 0;

  always #2 clk = ~clk;

  dbg_rd_engine #(.CNT_W(CNT_W), .AW(AW)) dut (.*);

  function automatic logic [63:0] mem_of(input logic [31:0] a);
    return {a ^ 32'hA5C3_0000, ~a};
  endfunction

  // bus slave model: grant one cycle, then return the beats
  always @(negedge clk) begin
    bus_rvalid = 1'b0;
    bus_err = 1'b0;
    if (bus_gnt) bus_gnt = 1'b0;
    else if (beats_left > 0) begin
      bus_rvalid = 1'b1;
      bus_rdata = mem_of(bus_addr);
      bus_err = (beat_no == err_beat);
      beat_no++;
      beats_left = bus_err ? 0 : beats_left - 1;
    end else if (bus_req) begin
      bus_gnt = 1'b1;
      grants++;
      if (bus_burst) burst_grants++;
      beat_no = 0;
      beats_left = bus_burst ? 4 : 1;
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      finish_run();
    end
  end

  task automatic set_addr(input logic [31:0] a);
    @(negedge clk); adr_we = 1'b1; adr_wdata = a;
    @(negedge clk); adr_we = 1'b0;
  endtask

  task automatic send_cmd(input int c, input int sz);
    @(negedge clk); ctl_we = 1'b1; ctl_cnt = CNT_W'(c); ctl_size = 2'(sz);
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic pop();
    @(negedge clk); dat_re = 1'b1;
    @(negedge clk); dat_re = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 100; i++) begin
      if (sts_valid || sts_err) return;
      @(negedge clk);
    end
    check(1'b0, "wait_done timeout", 0, 1);
  endtask

  task automatic wait_cnt(input logic [CNT_W-1:0] prev);
    for (int i = 0; i < 100; i++) begin
      if (sts_cnt != prev || sts_err) return;
      @(negedge clk);
    end
    check(1'b0, "wait_cnt timeout", 0, 1);
  endtask

  initial begin
    int g0;
    logic [31:0] a;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    check(!sts_valid && !sts_err && !bus_req, "R9 reset", {sts_valid, sts_err, bus_req}, 0);

    // R1 single reads over all sizes, counts 0 and 1
    for (int sz = 0; sz < 4; sz++) begin
      for (int c = 0; c < 2; c++) begin
        a = 32'h1000 + 32'(sz * 64 + c * 8);
        set_addr(a);
        g0 = grants;
        send_cmd(c, sz);
        check(!sts_valid && bus_req, "R9 cmd clears valid, raises req", {sts_valid, bus_req}, 2'b01);
        wait_done();
        check(sts_valid && !sts_err, "R1 valid", {sts_valid, sts_err}, 2'b10);
        check(dat_rdata == mem_of(a), "R1 data", dat_rdata, mem_of(a));
        check(sts_addr == a, "R1 address kept", sts_addr, a);
        check(grants - g0 == 1, "R1 one access", grants - g0, 1);
      end
    end

    // R2 R3 R4 block reads
    for (int sz = 0; sz < 4; sz++) begin
      for (int n = 2; n < 6; n++) begin
        if (n == 4 && sz == 3) continue;
        a = 32'h2000 + 32'(sz * 256 + n * 32);
        set_addr(a);
        g0 = grants;
        send_cmd(n, sz);
        for (int i = 0; i < n; i++) begin
          logic [31:0] wa;
          wait_cnt(CNT_W'(n - i));
          wa = a + 32'(i * (1 << sz));
          check(sts_cnt == CNT_W'(n - i - 1), "R3 count step", sts_cnt, n - i - 1);
          check(dat_rdata == mem_of(wa), "R3 word data", dat_rdata, mem_of(wa));
          check(sts_addr == a + 32'((i + 1) * (1 << sz)), "R2 increment", sts_addr, a + 32'((i + 1) * (1 << sz)));
          if (i < n - 1) begin
            check(!sts_valid, "R4 valid low mid-block", sts_valid, 0);
            repeat (5) @(negedge clk);
            check(!bus_req && sts_cnt == CNT_W'(n - i - 1), "R3 waits for tool read", bus_req, 0);
            if (sz == 2 && n == 3 && i == 0) begin
              logic [31:0] held;
              held = sts_addr;
              send_cmd(9, 0);
              set_addr(32'hDEAD_0000);
              check(sts_cnt == CNT_W'(2), "R8 command ignored", sts_cnt, 2);
              check(sts_addr == held, "R8 address ignored", sts_addr, held);
            end
            pop();
          end else begin
            check(sts_valid && !sts_err, "R4 valid at end", sts_valid, 1);
          end
        end
        check(grants - g0 == n, "R3 accesses", grants - g0, n);
      end
    end

    // R5 R6 burst
    a = 32'h4000;
    set_addr(a);
    g0 = burst_grants;
    send_cmd(4, 3);
    wait_done();
    check(sts_valid && sts_cnt == 0, "R5 done", {sts_valid, sts_cnt}, {1'b1, 8'd0});
    check(sts_addr == a + 32, "R5 address", sts_addr, a + 32);
    check(burst_grants - g0 == 1, "R5 one burst grant", burst_grants - g0, 1);
    for (int k = 0; k < 5; k++) begin
      logic [31:0] ea;
      ea = a + 32'((k < 4 ? k : 3) * 8);
      check(dat_rdata == mem_of(ea), "R6 buffer pop", dat_rdata, mem_of(ea));
      pop();
    end

    // R7 error on third burst beat
    a = 32'h5000;
    set_addr(a);
    err_beat = 2;
    send_cmd(4, 3);
    wait_done();
    check(sts_err && !sts_valid, "R7 burst error flags", {sts_err, sts_valid}, 2'b10);
    check(sts_cnt == 2, "R7 count kept", sts_cnt, 2);
    check(sts_addr == a + 16, "R7 address kept", sts_addr, a + 16);
    repeat (6) @(negedge clk);
    check(!bus_req && sts_err, "R7 stopped", bus_req, 0);

    // R7 error on single read
    err_beat = 0;
    send_cmd(1, 2);
    wait_done();
    check(sts_err && !sts_valid && sts_cnt == 1 && sts_addr == a + 16, "R7 single error", sts_cnt, 1);

    // R9 new command clears error
    err_beat = -1;
    send_cmd(1, 2);
    check(!sts_err && !sts_valid, "R9 error cleared", sts_err, 0);
    wait_done();
    check(sts_valid && dat_rdata == mem_of(a + 16), "R9 recovery read", dat_rdata, mem_of(a + 16));

    finish_run();
  end
endmodule